// File: doc/BRIEF.md
# Radio Packet Receive Handler

This block sits behind a demodulator and turns its serial bit stream into packet bytes. Each bit arrives with a one-cycle valid strobe. The block hunts for a configured 16- or 32-bit sync word. That match fixes the byte boundaries for the rest of the packet. It then strips an optional data whitening, reads either a length byte or a configured fixed count, filters on an optional address byte, and checks a CRC-16 trailer.

Every accepted byte goes to a receive FIFO through a byte-wide write strobe. When status appending is enabled, two more bytes follow the payload. The first is an RSSI sample. The second packs a CRC-good flag with a link-quality value. Some packets are abandoned before any byte is written: those whose length byte exceeds the configured maximum, and those whose address does not match. In both cases the block goes back to hunting for sync, one bit at a time.

Top module: `pkt_rx_handler`

## Requirements
- R1: After reset nothing is written. A sync is found only when the most recent bits, MSB first, equal the low 16 bits of the sync word (short mode) or all 32 bits (long mode). At least that many bits must have been received since the search began, so a partial match is ignored.
- R2: The first bit after the last sync bit is the MSB of the first packet byte, and every byte is assembled MSB first.
- R3: When whitening is on, every post-sync byte, including the CRC bytes, is XORed with a mask before any other use. The mask comes from a 9-bit register seeded 0x1FF at sync. The mask is its low 8 bits. After each byte the register steps 8 times; each step shifts it right by one and feeds bit0 XOR bit5 into bit 8. When whitening is off, bytes pass unchanged.
- R4: In variable mode the first byte is the length. It is written to the FIFO first, and exactly that many further bytes follow it. A length of 0 yields only the length byte.
- R5: In variable mode, a length byte greater than the configured maximum drops the packet. No byte of it is written.
- R6: In fixed mode there is no length byte, and exactly the configured number of bytes is taken as payload.
- R7: With address filtering on, the first byte after the length (or the first byte in fixed mode) must equal the configured address. If it does not, no byte of the packet is written. If it does, the length (if any) and the address are written in that order.
- R8: With CRC on, the CRC uses polynomial 0x8005, starts at 0xFFFF and shifts MSB first. It runs over the de-whitened length, address and payload bytes and then over the two received CRC bytes (high byte first). A zero result means the CRC is good. The CRC bytes are never written.
- R9: With status on, two bytes follow the payload. The first is `rssi_in`. The second has the CRC-good flag in bit 7 and `lqi_in` in bits 6:0, and its bit 7 is 0 whenever CRC checking is off. With status off, neither byte is written.
- R10: After a dropped packet the hunt restarts bit by bit from an empty history, so a packet that follows at once is received.
- R11: FIFO bytes appear in stream order, one per write strobe, and no byte other than those listed above is ever written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_in | input | 1 | Demodulated data bit |
| bit_vld | input | 1 | One-cycle strobe marking `bit_in` valid |
| cfg_sync_word | input | SYNC_W | Sync pattern, MSB sent first |
| cfg_sync_long | input | 1 | 1: match all SYNC_W bits, 0: match the low half |
| cfg_var_len | input | 1 | 1: length byte leads the packet, 0: fixed count |
| cfg_len | input | 8 | Maximum length (variable) or byte count (fixed) |
| cfg_addr_en | input | 1 | Enable address filtering |
| cfg_addr | input | 8 | Address to accept |
| cfg_crc_en | input | 1 | Expect and check a CRC-16 trailer |
| cfg_white_en | input | 1 | Undo whitening on post-sync bytes |
| cfg_status_en | input | 1 | Append the two status bytes |
| rssi_in | input | 8 | Signal strength, sampled at packet end |
| lqi_in | input | 7 | Link quality, sampled at packet end |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write data |

## Verification
Some properties are checked by assertions on every cycle. A write is never started from the hunt state except for the deferred address byte. The payload byte counter stays within the configured count. A length that passed into the payload state never exceeds the maximum. The second status byte has bit 7 clear when CRC checking is off. The bench's directed scenarios are needed for the rest: exact sync matching in both widths, the whitening sequence, CRC residue results for good and corrupted trailers, dropping on length and address, and recovery onto a packet that follows straight after a dropped one.

// File: rtl/pkt_rx_handler.sv
module pkt_rx_handler #(
  parameter int SYNC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_vld,
  input  logic [SYNC_W-1:0] cfg_sync_word,
  input  logic              cfg_sync_long,
  input  logic              cfg_var_len,
  input  logic [7:0]        cfg_len,
  input  logic              cfg_addr_en,
  input  logic [7:0]        cfg_addr,
  input  logic              cfg_crc_en,
  input  logic              cfg_white_en,
  input  logic              cfg_status_en,
  input  logic [7:0]        rssi_in,
  input  logic [6:0]        lqi_in,
  output logic              fifo_wr,
  output logic [7:0]        fifo_data
);

  localparam int CW   = $clog2(SYNC_W + 1);
  localparam int HALF = SYNC_W / 2;

  typedef enum logic [2:0] {HUNT, LEN, PAY, CRC, ST1, ST2} st_t;

  st_t              state;
  logic [SYNC_W-1:0] sync_sr;
  logic [CW-1:0]    sync_cnt;
  logic [7:0]       byte_sr;
  logic [2:0]       bit_cnt;
  logic [8:0]       lfsr, lfsr_adv;
  logic [15:0]      crc, crc_nx;
  logic [7:0]       rem, len_q, pend_byte;
  logic             first, crc_half, crc_ok, pend;
  logic [6:0]       lqi_q;

  logic [SYNC_W-1:0] sync_nx, sync_mask;
  logic [CW-1:0]     cnt_nx, sync_need;
  logic              sync_hit, byte_done, addr_bad;
  logic [7:0]        raw, dw;
  st_t               tail_st, crc_tail;

  assign sync_nx   = {sync_sr[SYNC_W-2:0], bit_in};
  assign sync_mask = cfg_sync_long ? {SYNC_W{1'b1}} : ({SYNC_W{1'b1}} >> HALF);
  assign sync_need = cfg_sync_long ? CW'(SYNC_W) : CW'(HALF);
  assign cnt_nx    = (sync_cnt == CW'(SYNC_W)) ? sync_cnt : sync_cnt + 1'b1;
  assign sync_hit  = bit_vld && state == HUNT && cnt_nx >= sync_need &&
                     ((sync_nx ^ cfg_sync_word) & sync_mask) == '0;

  assign raw       = {byte_sr[6:0], bit_in};
  assign dw        = raw ^ (cfg_white_en ? lfsr[7:0] : 8'h00);
  assign byte_done = bit_vld && bit_cnt == 3'd7 &&
                     (state == LEN || state == PAY || state == CRC);
  assign addr_bad  = first && cfg_addr_en && dw != cfg_addr;
  assign crc_tail  = cfg_status_en ? ST1 : HUNT;
  assign tail_st   = cfg_crc_en ? CRC : crc_tail;

  always_comb begin
    lfsr_adv = lfsr;
    for (int i = 0; i < 8; i++) lfsr_adv = {lfsr_adv[0] ^ lfsr_adv[5], lfsr_adv[8:1]};
  end

  always_comb begin
    crc_nx = crc;
    for (int i = 7; i >= 0; i--)
      crc_nx = {crc_nx[14:0], 1'b0} ^ ((crc_nx[15] ^ dw[i]) ? 16'h8005 : 16'h0000);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HUNT;  sync_sr <= '0;  sync_cnt <= '0;
      byte_sr <= '0;  bit_cnt <= '0;  lfsr <= 9'h1FF;  crc <= 16'hFFFF;
      rem <= '0;  len_q <= '0;  pend_byte <= '0;  lqi_q <= '0;
      first <= 1'b0;  crc_half <= 1'b0;  crc_ok <= 1'b0;  pend <= 1'b0;
      fifo_wr <= 1'b0;  fifo_data <= '0;
    end else begin
      fifo_wr <= 1'b0;
      if (pend) begin
        fifo_wr <= 1'b1;  fifo_data <= pend_byte;  pend <= 1'b0;
      end
      if (bit_vld && (state == LEN || state == PAY || state == CRC)) begin
        byte_sr <= raw;
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (byte_done) begin
        lfsr <= lfsr_adv;
        crc  <= crc_nx;
      end
      case (state)
        HUNT: if (bit_vld) begin
          sync_sr  <= sync_nx;
          sync_cnt <= cnt_nx;
          if (sync_hit) begin
            sync_sr <= '0;  sync_cnt <= '0;
            bit_cnt <= '0;  lfsr <= 9'h1FF;  crc <= 16'hFFFF;
            rem <= cfg_len;  first <= 1'b1;  crc_half <= 1'b0;  crc_ok <= 1'b0;
            if (cfg_var_len)          state <= LEN;
            else if (cfg_len == 8'd0) state <= tail_st;
            else                      state <= PAY;
          end
        end
        LEN: if (byte_done) begin
          if (dw > cfg_len) state <= HUNT;
          else begin
            len_q <= dw;
            rem   <= dw;
            if (dw == 8'd0) begin
              fifo_wr <= 1'b1;  fifo_data <= dw;  state <= tail_st;
            end else begin
              if (!cfg_addr_en) begin
                fifo_wr <= 1'b1;  fifo_data <= dw;
              end
              state <= PAY;
            end
          end
        end
        PAY: if (byte_done) begin
          rem   <= rem - 1'b1;
          first <= 1'b0;
          if (addr_bad) state <= HUNT;
          else begin
            fifo_wr <= 1'b1;
            if (first && cfg_addr_en && cfg_var_len) begin
              fifo_data <= len_q;  pend <= 1'b1;  pend_byte <= dw;
            end else fifo_data <= dw;
            if (rem == 8'd1) state <= tail_st;
          end
        end
        CRC: if (byte_done) begin
          crc_half <= 1'b1;
          if (crc_half) begin
            crc_ok <= (crc_nx == 16'h0000);
            state  <= crc_tail;
          end
        end
        ST1: if (!pend) begin
          fifo_wr <= 1'b1;  fifo_data <= rssi_in;  lqi_q <= lqi_in;  state <= ST2;
        end
        ST2: begin
          fifo_wr <= 1'b1;  fifo_data <= {crc_ok, lqi_q};  state <= HUNT;
        end
        default: state <= HUNT;
      endcase
    end
  end

  // R1
  sync_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_cnt <= CW'(SYNC_W));

  // R11
  wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && !$past(pend)) |-> $past(state != HUNT));

  // R4
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PAY) |-> (rem != 8'd0 && rem <= cfg_len));

  // R5
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PAY && cfg_var_len) |-> len_q <= cfg_len);

  // R9
  status_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && $past(state == ST2) && !cfg_crc_en) |-> !fifo_data[7]);

endmodule

// File: tb/pkt_rx_handler_tb_top.sv
`timescale 1ns/1ps
module pkt_rx_handler_tb_top;

  localparam logic [31:0] SYNC = 32'h1234_D391;
  localparam logic [7:0]  RSSI = 8'h5C;
  localparam logic [6:0]  LQI  = 7'h2B;

  logic clk = 1'b0, rst_n = 1'b0, bit_in = 1'b0, bit_vld = 1'b0;
  logic        cfg_sync_long = 1'b0, cfg_var_len = 1'b1, cfg_addr_en = 1'b0;
  logic        cfg_crc_en = 1'b1, cfg_white_en = 1'b0, cfg_status_en = 1'b1;
  logic [7:0]  cfg_len = 8'd10, cfg_addr = 8'h3C;
  logic        fifo_wr;
  logic [7:0]  fifo_data;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] tx_q[$], wire_q[$], exp_q[$], got_q[$];

  always #2 clk = ~clk;

  pkt_rx_handler #(.SYNC_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .cfg_sync_word(SYNC), .cfg_sync_long(cfg_sync_long), .cfg_var_len(cfg_var_len),
    .cfg_len(cfg_len), .cfg_addr_en(cfg_addr_en), .cfg_addr(cfg_addr),
    .cfg_crc_en(cfg_crc_en), .cfg_white_en(cfg_white_en), .cfg_status_en(cfg_status_en),
    .rssi_in(RSSI), .lqi_in(LQI), .fifo_wr(fifo_wr), .fifo_data(fifo_data));

  always @(negedge clk) if (rst_n && fifo_wr) got_q.push_back(fifo_data);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    for (int k = 7; k >= 0; k--) c = (c[15] ^ b[k]) ? ((c << 1) ^ 16'h8005) : (c << 1);
    return c;
  endfunction

  task automatic make_wire(input bit add_crc);
    logic [15:0] c = 16'hFFFF;
    logic [8:0]  pn = 9'h1FF;
    wire_q = {};
    foreach (tx_q[i]) begin
      c = crc_byte(c, tx_q[i]);
      wire_q.push_back(tx_q[i]);
    end
    if (add_crc) begin
      wire_q.push_back(c[15:8]);
      wire_q.push_back(c[7:0]);
    end
    if (cfg_white_en)
      foreach (wire_q[i]) begin
        wire_q[i] = wire_q[i] ^ pn[7:0];
        for (int s = 0; s < 8; s++) pn = {pn[0] ^ pn[5], pn[8:1]};
      end
  endtask

  task automatic send_bit(input logic b);
    bit_in = b;  bit_vld = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) send_bit(b[k]);
  endtask

  task automatic send_frame(input bit full_sync);
    send_byte(8'hAA);
    send_byte(8'hAA);
    for (int k = (full_sync && cfg_sync_long) ? 31 : 15; k >= 0; k--) send_bit(SYNC[k]);
    foreach (wire_q[i]) send_byte(wire_q[i]);
  endtask

  task automatic expect_tx(input bit status, input bit ok);
    foreach (tx_q[i]) exp_q.push_back(tx_q[i]);
    if (status) begin
      exp_q.push_back(RSSI);
      exp_q.push_back({ok, LQI});
    end
  endtask

  task automatic cmp_queue(input string tag);
    repeat (20) @(negedge clk);
    chk({tag, " count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      chk($sformatf("%s byte %0d", tag, i), got_q[i], exp_q[i]);
    got_q = {};
    exp_q = {};
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk("R1 reset no write", fifo_wr, 1'b0);
    chk("R1 reset queue", got_q.size(), 0);
  endtask

  task automatic t_var_basic();
    cfg_var_len = 1; cfg_crc_en = 1; cfg_status_en = 1; cfg_white_en = 0; cfg_addr_en = 0;
    tx_q = '{8'd3, 8'h11, 8'h22, 8'h33};
    make_wire(1); send_frame(1); expect_tx(1, 1);
    cmp_queue("R2 R4 R8 R9 variable packet");
  endtask

  task automatic t_white();
    cfg_white_en = 1;
    tx_q = '{8'd4, 8'h00, 8'hFF, 8'h5A, 8'h80};
    make_wire(1); send_frame(1); expect_tx(1, 1);
    cmp_queue("R3 whitened packet");
    cfg_white_en = 0;
  endtask

  task automatic t_crc_bad();
    tx_q = '{8'd2, 8'h40, 8'h41};
    make_wire(1);
    wire_q[2] = wire_q[2] ^ 8'h01;
    tx_q[2] = tx_q[2] ^ 8'h01;
    send_frame(1); expect_tx(1, 0);
    cmp_queue("R8 corrupted crc flag");
  endtask

  task automatic t_fixed();
    cfg_var_len = 0; cfg_len = 8'd4; cfg_crc_en = 0; cfg_status_en = 0; cfg_white_en = 1;
    tx_q = '{8'h01, 8'h02, 8'hFE, 8'h7F};
    make_wire(0); send_frame(1); expect_tx(0, 0);
    cmp_queue("R6 R11 fixed packet");
    cfg_var_len = 1; cfg_len = 8'd10; cfg_white_en = 0;
  endtask

  task automatic t_addr_ok();
    cfg_addr_en = 1; cfg_crc_en = 1; cfg_status_en = 1;
    tx_q = '{8'd3, 8'h3C, 8'hC3, 8'h99};
    make_wire(1); send_frame(1); expect_tx(1, 1);
    cmp_queue("R7 address match");
  endtask

  task automatic t_addr_bad();
    cfg_addr_en = 1; cfg_crc_en = 0; cfg_status_en = 1;
    tx_q = '{8'd3, 8'h77, 8'h00, 8'h00};
    make_wire(0); send_frame(1);
    tx_q = '{8'd2, 8'h3C, 8'h5E};
    make_wire(0); send_frame(1); expect_tx(1, 0);
    cmp_queue("R7 R10 R9 address drop then recover");
    cfg_addr_en = 0; cfg_crc_en = 1;
  endtask

  task automatic t_len_long();
    cfg_len = 8'd5; cfg_crc_en = 0; cfg_status_en = 0;
    tx_q = '{8'd9, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    make_wire(0); send_frame(1);
    tx_q = '{8'd2, 8'h61, 8'h62};
    make_wire(0); send_frame(1); expect_tx(0, 0);
    cmp_queue("R5 R10 long length drop then recover");
    cfg_len = 8'd10; cfg_crc_en = 1; cfg_status_en = 1;
  endtask

  task automatic t_sync32();
    cfg_sync_long = 1;
    tx_q = '{8'd2, 8'h0F, 8'hF0};
    make_wire(1); send_frame(0);
    cmp_queue("R1 partial long sync ignored");
    send_frame(1); expect_tx(1, 1);
    cmp_queue("R1 full long sync");
    cfg_sync_long = 0;
  endtask

  task automatic t_fixed_addr();
    cfg_var_len = 0; cfg_len = 8'd3; cfg_addr_en = 1; cfg_white_en = 1;
    tx_q = '{8'h3C, 8'h01, 8'h02};
    make_wire(1); send_frame(1); expect_tx(1, 1);
    cmp_queue("R6 R7 R3 fixed with address");
    cfg_var_len = 1; cfg_len = 8'd10; cfg_addr_en = 0; cfg_white_en = 0;
  endtask

  task automatic t_len_zero();
    tx_q = '{8'd0};
    make_wire(1); send_frame(1); expect_tx(1, 1);
    cmp_queue("R4 zero length");
  endtask

  task automatic t_status_off();
    cfg_status_en = 0;
    tx_q = '{8'd1, 8'hA5};
    make_wire(1); send_frame(1); expect_tx(0, 0);
    cmp_queue("R9 status disabled");
    cfg_status_en = 1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_var_basic();
    t_white();
    t_crc_bad();
    t_fixed();
    t_addr_ok();
    t_addr_bad();
    t_len_long();
    t_sync32();
    t_fixed_addr();
    t_len_zero();
    t_status_off();
    finish_run();
  end

  initial begin
    #600000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule